// File: doc/BRIEF.md
# Synthesizer Control Word Register

This block holds the main control word of a dual-band frequency synthesizer. A 24-bit word arrives one bit at a time through a serial shift interface. A rising edge on a latch strobe copies the word into a parallel control register. The register fields drive:

- the phase-detector polarity,
- the band choice,
- an input-response mode,
- standby,
- a two-bit high-band detector response,
- a general-purpose output pin,
- the frequency-counter acquisition-window select,
- the frequency-sample enable,
- a 14-bit reference divide ratio.

Power-up reset loads a fixed default word, and that default leaves the part in standby. A word that carries the reset-request bit does not store its own fields. Instead it reloads the defaults and raises a one-cycle internal reset pulse for the rest of the device. The serial shift register keeps its contents. The block also derives the detector, reference-output and counter enables from the band and standby fields, and it signals aborts to a frequency count or a conversion that is running during standby. A latch strobe that arrives while the frequency counter and the converter are both busy is refused, and an error pulse reports it.

Top module: `synth_ctrl_reg`

## Requirements
- R1: After `rst`, the outputs are: `standby`=1; `pol_inv`, `band_hi`, `in_resp`, `det_resp`, `gpo`, `acq_wide`, `fsample_en` and `ref_div` all 0; `core_rst`=0 and `wr_err`=0.
- R2: On each `clk` edge with `shift_en`=1, `sdi` is shifted into a 24-bit serial register, MSB first. The first bit shifted becomes word bit 23.
- R3: The control register loads the serial word only on a clock where `load` has gone from 0 to 1. Holding `load` high while new bits are shifted does not change the outputs.
- R4: Field positions in the word are: bit 23 `pol_inv`, bit 22 reset request, bit 21 `band_hi`, bit 20 `in_resp`, bit 19 `standby`, bits 18:17 `det_resp`, bit 16 `gpo`, bit 15 `acq_wide`, bit 14 `fsample_en`, bits 13:0 `ref_div`.
- R5: An accepted word with bit 22 = 1 has these effects:
  - The R1 default fields are loaded; the word's other fields are not.
  - `core_rst` is high for exactly the one cycle after the latch.
  - The serial register keeps its contents, so a second strobe without new shifting repeats the reset.
- R6: `lo_det_en` = !standby & !band_hi; `hi_det_en` = !standby & band_hi; `ref_out_en` = !standby & !band_hi; `cnt_en` = !standby.
- R7: `abort_cnt` = standby & `fcnt_busy`, and `abort_adc` = standby & `adc_busy`. Both follow their inputs in the same cycle.
- R8: A strobe edge while `fcnt_busy` and `adc_busy` are both 1 leaves the register unchanged and raises `wr_err` for exactly one cycle. A strobe edge with only one of them busy is accepted.
- R9: `fsample_en` stays at its written value until the next accepted write, whatever `fcnt_busy` or `adc_busy` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sdi | input | 1 | Serial data bit |
| shift_en | input | 1 | Shift `sdi` in on this edge |
| load | input | 1 | Latch strobe; acts on its rising edge |
| fcnt_busy | input | 1 | Frequency counter is counting |
| adc_busy | input | 1 | Converter is converting |
| pol_inv | output | 1 | Invert both detector outputs |
| band_hi | output | 1 | High band selected |
| in_resp | output | 1 | Low-band IF input response mode |
| standby | output | 1 | Standby state |
| det_resp | output | 2 | High-band detector response / test mode |
| gpo | output | 1 | General-purpose output pin |
| acq_wide | output | 1 | Wide acquisition window |
| fsample_en | output | 1 | Frequency-sample enable |
| ref_div | output | 14 | Reference counter divide ratio |
| lo_det_en | output | 1 | Low-band detector output enabled |
| hi_det_en | output | 1 | High-band detector output enabled |
| ref_out_en | output | 1 | Reference output enabled |
| cnt_en | output | 1 | Counters allowed to toggle |
| abort_cnt | output | 1 | Abort frequency count |
| abort_adc | output | 1 | Abort conversion |
| core_rst | output | 1 | One-cycle device reset pulse |
| wr_err | output | 1 | Refused-write pulse |

## Verification
The bench holds `load` high while a second word is shifted in. A design that latches on the level of `load`, rather than on its edge, picks up that second word. It writes a reset-request word and then strobes again without shifting. A design that cleared the serial register, or stored bit 22, would show no second `core_rst` pulse, or would hold the reset state. It strobes with both busy flags set and with each flag set alone. This catches a lockout that uses OR instead of AND, or that still writes the register. A wrong field map, a wrong default or a wrong enable equation shows up as a mismatch against the expected word in the vector walk.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
    localparam int DIV_W  = 14;
    localparam int WORD_W = DIV_W + 10;

    typedef struct packed {
        logic             pol;
        logic             rst_req;
        logic             band;
        logic             resp;
        logic             stby;
        logic [1:0]       det;
        logic             gpo;
        logic             acq;
        logic             fsmp;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c      = '0;
        c.stby = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t ctrl_next(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c = ctrl_t'(w);
        if (c.rst_req) c = ctrl_default();
        c.rst_req = 1'b0;
        return c;
    endfunction
endpackage

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdi,
    input  logic         shift_en,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_en) word <= {word[W-2:0], sdi};
    end

    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (word[0] == $past(sdi)));
endmodule

// File: rtl/strobe_guard.sv
module strobe_guard (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic fcnt_busy,
    input  logic adc_busy,
    output logic accept,
    output logic wr_err
);
    logic load_q;
    logic rise;

    always_comb begin
        rise   = load & ~load_q;
        accept = rise & ~(fcnt_busy & adc_busy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            load_q <= load;
            wr_err <= rise & fcnt_busy & adc_busy;
        end
    end

    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !wr_err);
    a_r3_edge_only: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept);
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode (
    input  logic clk,
    input  logic rst,
    input  logic stby,
    input  logic band,
    input  logic fcnt_busy,
    input  logic adc_busy,
    output logic lo_det_en,
    output logic hi_det_en,
    output logic ref_out_en,
    output logic cnt_en,
    output logic abort_cnt,
    output logic abort_adc
);
    always_comb begin
        cnt_en     = ~stby;
        lo_det_en  = cnt_en & ~band;
        hi_det_en  = cnt_en & band;
        ref_out_en = lo_det_en;
        abort_cnt  = stby & fcnt_busy;
        abort_adc  = stby & adc_busy;
    end

    a_r6_one_band: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lo_det_en, hi_det_en}));
    a_r7_abort_in_stby: assert property (@(posedge clk) disable iff (rst)
        (abort_cnt || abort_adc) |-> !cnt_en);
endmodule

// File: rtl/synth_ctrl_reg.sv
module synth_ctrl_reg
    import synth_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sdi,
    input  logic             shift_en,
    input  logic             load,
    input  logic             fcnt_busy,
    input  logic             adc_busy,
    output logic             pol_inv,
    output logic             band_hi,
    output logic             in_resp,
    output logic             standby,
    output logic [1:0]       det_resp,
    output logic             gpo,
    output logic             acq_wide,
    output logic             fsample_en,
    output logic [DIV_W-1:0] ref_div,
    output logic             lo_det_en,
    output logic             hi_det_en,
    output logic             ref_out_en,
    output logic             cnt_en,
    output logic             abort_cnt,
    output logic             abort_adc,
    output logic             core_rst,
    output logic             wr_err
);
    logic [WORD_W-1:0] sword;
    logic              accept;
    ctrl_t             ctrl_q;
    ctrl_t             in_word;

    ser_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en), .word(sword)
    );

    strobe_guard u_guard (
        .clk(clk), .rst(rst), .load(load), .fcnt_busy(fcnt_busy),
        .adc_busy(adc_busy), .accept(accept), .wr_err(wr_err)
    );

    assign in_word = ctrl_t'(sword);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= ctrl_default();
            core_rst <= 1'b0;
        end else begin
            core_rst <= accept & in_word.rst_req;
            if (accept) ctrl_q <= ctrl_next(sword);
        end
    end

    assign pol_inv    = ctrl_q.pol;
    assign band_hi    = ctrl_q.band;
    assign in_resp    = ctrl_q.resp;
    assign standby    = ctrl_q.stby;
    assign det_resp   = ctrl_q.det;
    assign gpo        = ctrl_q.gpo;
    assign acq_wide   = ctrl_q.acq;
    assign fsample_en = ctrl_q.fsmp;
    assign ref_div    = ctrl_q.div;

    ctrl_decode u_dec (
        .clk(clk), .rst(rst), .stby(ctrl_q.stby), .band(ctrl_q.band),
        .fcnt_busy(fcnt_busy), .adc_busy(adc_busy),
        .lo_det_en(lo_det_en), .hi_det_en(hi_det_en), .ref_out_en(ref_out_en),
        .cnt_en(cnt_en), .abort_cnt(abort_cnt), .abort_adc(abort_adc)
    );

    a_r8_refused_holds: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $stable(ctrl_q));
    a_r5_reset_defaults: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (standby && !gpo && !fsample_en && !pol_inv));
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !core_rst);
    a_r9_fsmp_sticky: assert property (@(posedge clk) disable iff (rst)
        (!accept && !core_rst) |=> $stable(fsample_en));
endmodule

// File: tb/tb_synth_ctrl_reg.sv
module tb_synth_ctrl_reg;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sdi = 1'b0, shift_en = 1'b0, load = 1'b0, fcnt_busy = 1'b0, adc_busy = 1'b0;
    logic pol_inv, band_hi, in_resp, standby, gpo, acq_wide, fsample_en;
    logic [1:0] det_resp;
    logic [13:0] ref_div;
    logic lo_det_en, hi_det_en, ref_out_en, cnt_en, abort_cnt, abort_adc, core_rst, wr_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    synth_ctrl_reg dut (
        .clk(clk), .rst(rst), .sdi(sdi), .shift_en(shift_en), .load(load),
        .fcnt_busy(fcnt_busy), .adc_busy(adc_busy),
        .pol_inv(pol_inv), .band_hi(band_hi), .in_resp(in_resp), .standby(standby),
        .det_resp(det_resp), .gpo(gpo), .acq_wide(acq_wide), .fsample_en(fsample_en),
        .ref_div(ref_div), .lo_det_en(lo_det_en), .hi_det_en(hi_det_en),
        .ref_out_en(ref_out_en), .cnt_en(cnt_en), .abort_cnt(abort_cnt),
        .abort_adc(abort_adc), .core_rst(core_rst), .wr_err(wr_err)
    );

    localparam logic [23:0] DEF = 24'h08_0000;
    // {fcnt_busy, adc_busy, word}
    localparam logic [25:0] VEC [6] = '{
        {2'b00, 24'hA5_3C7F},
        {2'b10, 24'h1B_C123},
        {2'b11, 24'h80_0001},
        {2'b01, 24'h21_4000},
        {2'b00, 24'h40_FFFF},
        {2'b00, 24'h83_BFFF}
    };

    function automatic logic [23:0] obs();
        return {pol_inv, 1'b0, band_hi, in_resp, standby, det_resp, gpo,
                acq_wide, fsample_en, ref_div};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk);
            sdi = w[i];
            shift_en = 1'b1;
        end
        @(negedge clk);
        shift_en = 1'b0;
    endtask

    task automatic check_state(input logic [23:0] e, input string req);
        logic s, b;
        s = e[19];
        b = e[21];
        chk(obs() == e, req, {8'h0, obs()}, {8'h0, e});
        chk({lo_det_en, hi_det_en, ref_out_en, cnt_en} == {!s && !b, !s && b, !s && !b, !s},
            "R6", {28'h0, lo_det_en, hi_det_en, ref_out_en, cnt_en},
            {28'h0, !s && !b, !s && b, !s && !b, !s});
        chk({abort_cnt, abort_adc} == {s & fcnt_busy, s & adc_busy}, "R7",
            {30'h0, abort_cnt, abort_adc}, {30'h0, s & fcnt_busy, s & adc_busy});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] exp_w;
        logic [23:0] w;
        logic acc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_state(DEF, "R1");
        chk({core_rst, wr_err} == 2'b00, "R1", {30'h0, core_rst, wr_err}, 32'h0);
        exp_w = DEF;

        // R2 R4 R5 R8: vector walk
        for (int k = 0; k < 6; k++) begin
            w = VEC[k][23:0];
            shift_word(w);
            @(negedge clk);
            fcnt_busy = VEC[k][25];
            adc_busy  = VEC[k][24];
            load = 1'b1;
            acc = !(VEC[k][25] && VEC[k][24]);
            if (acc) exp_w = w[22] ? DEF : (w & ~24'h40_0000);
            @(negedge clk);
            load = 1'b0;
            check_state(exp_w, acc ? (w[22] ? "R5" : "R4") : "R8");
            chk(wr_err == !acc, "R8", {31'h0, wr_err}, {31'h0, !acc});
            chk(core_rst == (acc && w[22]), "R5", {31'h0, core_rst}, {31'h0, acc && w[22]});
            fcnt_busy = 1'b0;
            adc_busy = 1'b0;
            @(negedge clk);
            chk({wr_err, core_rst} == 2'b00, "R8", {30'h0, wr_err, core_rst}, 32'h0);
        end

        // R3: held strobe does not reload
        shift_word(24'h02_1111);
        @(negedge clk); load = 1'b1;
        @(negedge clk);
        shift_word(24'h21_2222);
        @(negedge clk);
        check_state(24'h02_1111, "R3");
        load = 1'b0;
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check_state(24'h21_2222, "R3");

        // R9: frequency-sample bit sticky across busy activity
        shift_word(24'h01_4005);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            fcnt_busy = j[0];
            adc_busy = j[1];
        end
        @(negedge clk);
        fcnt_busy = 1'b0; adc_busy = 1'b0;
        chk(fsample_en == 1'b1, "R9", {31'h0, fsample_en}, 32'h1);

        // R5: serial register spared, second strobe repeats reset
        shift_word(24'h40_0000);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk(core_rst == 1'b1, "R5", {31'h0, core_rst}, 32'h1);
        @(negedge clk);
        shift_word(24'h00_0001);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        check_state(24'h00_0001, "R2");
        shift_word(24'h40_0000);
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        chk(core_rst == 1'b1, "R5", {31'h0, core_rst}, 32'h1);
        check_state(DEF, "R5");

        // R7: aborts in standby follow busy inputs
        @(negedge clk);
        fcnt_busy = 1'b1; adc_busy = 1'b0;
        #1;
        chk({abort_cnt, abort_adc} == 2'b10, "R7", {30'h0, abort_cnt, abort_adc}, 32'h2);
        @(negedge clk);
        fcnt_busy = 1'b0; adc_busy = 1'b1;
        #1;
        chk({abort_cnt, abort_adc} == 2'b01, "R7", {30'h0, abort_cnt, abort_adc}, 32'h1);
        adc_busy = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule